// File: doc/BRIEF.md
# Flash Controller Ownership Handover Switch

This block sits in front of a single flash controller and lets two masters share it: the host processor, which normally owns the controller, and an update engine that takes it over for short bursts while it writes pages and polls flash status. The controller exposes two request paths. One carries register accesses and the other carries memory-mapped data reads and writes. The switch moves both paths from one master to the other in a single step.

When the engine raises its ownership request, the switch stops accepting new host requests on both paths. It then waits until every transaction already sent to the controller has returned its response, and only then grants the engine. Host requests are stalled, not rejected. A host read stream therefore pauses during the engine's phase and continues when the engine drops its request. Every accepted request produces exactly one response on the same path, and responses return in request order. Each response is steered to the master that issued the matching request, even when ownership has changed since that request was sent.

The engine may claim and release ownership as often as it needs during one update. A request that is withdrawn before it is granted returns the block to host ownership.

Top module: `flash_bus_handover`

## Requirements
- R1: During and right after reset, the grant output is low, the host owns both paths, engine ready is low on both paths, and nothing is outstanding.
- R2: While the host owns the paths and `eng_req` is low, a host request is forwarded to the controller with its write flag, address and write data unchanged. Host ready equals controller ready as long as fewer than MAX_OUT transactions are outstanding on that path.
- R3: From the cycle in which `eng_req` is high, and for as long as the engine holds or owns the paths, host ready is low on both paths. A stalled host request is sent to the controller unchanged once the host owns the paths again.
- R4: `eng_grant` rises exactly one cycle after a cycle in which a handover is pending, `eng_req` is high, and both paths have zero outstanding transactions. It is never high while a host transaction is outstanding.
- R5: While `eng_grant` is high, both paths forward engine requests, and engine ready equals controller ready as long as fewer than MAX_OUT transactions are outstanding on that path.
- R6: While `eng_grant` is low, engine ready is low on both paths and engine requests do not reach the controller.
- R7: While granted, a low `eng_req` makes `eng_grant` fall on the next cycle. In that same cycle the host path reopens.
- R8: A controller response is delivered on the rvalid and rdata of the master that issued the oldest outstanding request on that path, including engine responses that arrive after release. Never both masters in one cycle.
- R9: A path with MAX_OUT transactions outstanding accepts no new request from either master and shows no request to the controller.
- R10: The engine can claim and release ownership repeatedly, and each claim goes through the full drain before it is granted.
- R11: If `eng_req` falls while the handover is still draining, the grant is never given and the host owns both paths again from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_req | input | 1 | Engine asks for ownership of both paths (level) |
| eng_grant | output | 1 | Engine owns both paths |
| hc_valid | input | 1 | Host register request valid |
| hc_ready | output | 1 | Host register request accepted |
| hc_write | input | 1 | Host register request is a write |
| hc_addr | input | CFG_AW | Host register address |
| hc_wdata | input | CFG_DW | Host register write data |
| hc_rvalid | output | 1 | Host register response valid |
| hc_rdata | output | CFG_DW | Host register response data |
| ec_valid | input | 1 | Engine register request valid |
| ec_ready | output | 1 | Engine register request accepted |
| ec_write | input | 1 | Engine register request is a write |
| ec_addr | input | CFG_AW | Engine register address |
| ec_wdata | input | CFG_DW | Engine register write data |
| ec_rvalid | output | 1 | Engine register response valid |
| ec_rdata | output | CFG_DW | Engine register response data |
| cc_valid | output | 1 | Register request to the controller |
| cc_ready | input | 1 | Controller accepts the register request |
| cc_write | output | 1 | Forwarded register write flag |
| cc_addr | output | CFG_AW | Forwarded register address |
| cc_wdata | output | CFG_DW | Forwarded register write data |
| cc_rvalid | input | 1 | Controller register response valid |
| cc_rdata | input | CFG_DW | Controller register response data |
| hd_valid | input | 1 | Host data request valid |
| hd_ready | output | 1 | Host data request accepted |
| hd_write | input | 1 | Host data request is a write |
| hd_addr | input | DAT_AW | Host data address |
| hd_wdata | input | DAT_DW | Host write data |
| hd_rvalid | output | 1 | Host data response valid |
| hd_rdata | output | DAT_DW | Host read data |
| ed_valid | input | 1 | Engine data request valid |
| ed_ready | output | 1 | Engine data request accepted |
| ed_write | input | 1 | Engine data request is a write |
| ed_addr | input | DAT_AW | Engine data address |
| ed_wdata | input | DAT_DW | Engine write data |
| ed_rvalid | output | 1 | Engine data response valid |
| ed_rdata | output | DAT_DW | Engine read data |
| cd_valid | output | 1 | Data request to the controller |
| cd_ready | input | 1 | Controller accepts the data request |
| cd_write | output | 1 | Forwarded data write flag |
| cd_addr | output | DAT_AW | Forwarded data address |
| cd_wdata | output | DAT_DW | Forwarded write data |
| cd_rvalid | input | 1 | Controller data response valid |
| cd_rdata | input | DAT_DW | Controller read data |

## Verification
The bench drives heavy host traffic on both paths against a controller with random acceptance and responses that arrive one to six cycles late. Because of this, ownership requests often arrive while host transactions are still outstanding. A switch that granted too early would forward an engine request while host responses were still due, and those responses would then be misrouted. Engine traffic that is still pending at release exercises the response steering. A switch that routed responses by current owner would hand the late engine responses to the host. A small MAX_OUT makes the outstanding limit bind often, and a one-cycle request pulse checks that an abandoned drain returns to the host instead of leaving both masters stalled.

// File: rtl/fbh_pkg.sv
package fbh_pkg;

   typedef enum logic [1:0] {
      OWN_HOST  = 2'd0,
      OWN_DRAIN = 2'd1,
      OWN_ENG   = 2'd2
   } own_t;

endpackage

// File: rtl/fbh_owner_fsm.sv
module fbh_owner_fsm
   import fbh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic eng_req,
   input  logic cfg_idle,
   input  logic dat_idle,
   output own_t state,
   output logic host_open,
   output logic eng_own
);

   own_t state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         OWN_HOST:  if (eng_req) state_d = OWN_DRAIN;
         OWN_DRAIN: begin
            if (!eng_req)                  state_d = OWN_HOST;
            else if (cfg_idle && dat_idle) state_d = OWN_ENG;
         end
         OWN_ENG:   if (!eng_req) state_d = OWN_HOST;
         default:   state_d = OWN_HOST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= OWN_HOST;
      else        state <= state_d;
   end

   // host path closes in the very cycle the engine asks
   assign host_open = (state == OWN_HOST) && !eng_req;
   assign eng_own   = (state == OWN_ENG);

endmodule

// File: rtl/fbh_port_route.sv
module fbh_port_route #(
   parameter  int AW         = 8,
   parameter  int DW         = 32,
   parameter  int MAX_OUT    = 4,
   parameter  bit GATE_RDATA = 1'b1,
   localparam int CW         = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_open,
   input  logic          eng_own,
   input  logic          h_valid,
   output logic          h_ready,
   input  logic          h_write,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic          h_rvalid,
   output logic [DW-1:0] h_rdata,
   input  logic          e_valid,
   output logic          e_ready,
   input  logic          e_write,
   input  logic [AW-1:0] e_addr,
   input  logic [DW-1:0] e_wdata,
   output logic          e_rvalid,
   output logic [DW-1:0] e_rdata,
   output logic          c_valid,
   input  logic          c_ready,
   output logic          c_write,
   output logic [AW-1:0] c_addr,
   output logic [DW-1:0] c_wdata,
   input  logic          c_rvalid,
   input  logic [DW-1:0] c_rdata,
   output logic          idle,
   output logic [CW-1:0] busy
);

   if (MAX_OUT < 1) begin : g_bad_depth
      $error("fbh_port_route: MAX_OUT must be at least 1");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("fbh_port_route: widths must be positive");
   end

   logic [CW-1:0] h_cnt, e_cnt;
   logic          room, issue_h, issue_e, ret_h, ret_e, to_eng;

   assign busy = h_cnt + e_cnt;
   assign idle = (busy == '0);
   assign room = (busy < CW'(MAX_OUT));

   // request side: owner selects, limit gates
   assign h_ready = host_open && room && c_ready;
   assign e_ready = eng_own   && room && c_ready;
   assign c_valid = room && (eng_own ? e_valid : (host_open && h_valid));
   assign c_write = eng_own ? e_write : h_write;
   assign c_addr  = eng_own ? e_addr  : h_addr;
   assign c_wdata = eng_own ? e_wdata : h_wdata;

   assign issue_h = h_valid && h_ready;
   assign issue_e = e_valid && e_ready;

   // engine requests always precede later host ones, so in-order
   // responses belong to the engine while any engine one is open
   assign to_eng   = (e_cnt != '0);
   assign ret_h    = c_rvalid && !to_eng;
   assign ret_e    = c_rvalid &&  to_eng;
   assign h_rvalid = ret_h;
   assign e_rvalid = ret_e;

   if (GATE_RDATA) begin : g_gated
      assign h_rdata = ret_h ? c_rdata : '0;
      assign e_rdata = ret_e ? c_rdata : '0;
   end else begin : g_shared
      assign h_rdata = c_rdata;
      assign e_rdata = c_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_cnt <= '0;
         e_cnt <= '0;
      end else begin
         h_cnt <= h_cnt + CW'(issue_h) - CW'(ret_h);
         e_cnt <= e_cnt + CW'(issue_e) - CW'(ret_e);
      end
   end

endmodule

// File: rtl/flash_bus_handover.sv
module flash_bus_handover
   import fbh_pkg::*;
#(
   parameter int CFG_AW     = 8,
   parameter int CFG_DW     = 32,
   parameter int DAT_AW     = 24,
   parameter int DAT_DW     = 32,
   parameter int MAX_OUT    = 4,
   parameter bit GATE_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_req,
   output logic              eng_grant,
   input  logic              hc_valid,
   output logic              hc_ready,
   input  logic              hc_write,
   input  logic [CFG_AW-1:0] hc_addr,
   input  logic [CFG_DW-1:0] hc_wdata,
   output logic              hc_rvalid,
   output logic [CFG_DW-1:0] hc_rdata,
   input  logic              ec_valid,
   output logic              ec_ready,
   input  logic              ec_write,
   input  logic [CFG_AW-1:0] ec_addr,
   input  logic [CFG_DW-1:0] ec_wdata,
   output logic              ec_rvalid,
   output logic [CFG_DW-1:0] ec_rdata,
   output logic              cc_valid,
   input  logic              cc_ready,
   output logic              cc_write,
   output logic [CFG_AW-1:0] cc_addr,
   output logic [CFG_DW-1:0] cc_wdata,
   input  logic              cc_rvalid,
   input  logic [CFG_DW-1:0] cc_rdata,
   input  logic              hd_valid,
   output logic              hd_ready,
   input  logic              hd_write,
   input  logic [DAT_AW-1:0] hd_addr,
   input  logic [DAT_DW-1:0] hd_wdata,
   output logic              hd_rvalid,
   output logic [DAT_DW-1:0] hd_rdata,
   input  logic              ed_valid,
   output logic              ed_ready,
   input  logic              ed_write,
   input  logic [DAT_AW-1:0] ed_addr,
   input  logic [DAT_DW-1:0] ed_wdata,
   output logic              ed_rvalid,
   output logic [DAT_DW-1:0] ed_rdata,
   output logic              cd_valid,
   input  logic              cd_ready,
   output logic              cd_write,
   output logic [DAT_AW-1:0] cd_addr,
   output logic [DAT_DW-1:0] cd_wdata,
   input  logic              cd_rvalid,
   input  logic [DAT_DW-1:0] cd_rdata
);

   localparam int CW = $clog2(MAX_OUT + 1);

   own_t          own_state;
   logic          host_open, eng_own, cfg_idle, dat_idle;
   logic [CW-1:0] cfg_busy, dat_busy;

   fbh_owner_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .eng_req   (eng_req),
      .cfg_idle  (cfg_idle),
      .dat_idle  (dat_idle),
      .state     (own_state),
      .host_open (host_open),
      .eng_own   (eng_own)
   );

   assign eng_grant = eng_own;

   fbh_port_route #(
      .AW(CFG_AW), .DW(CFG_DW), .MAX_OUT(MAX_OUT), .GATE_RDATA(GATE_RDATA)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .host_open(host_open), .eng_own(eng_own),
      .h_valid(hc_valid), .h_ready(hc_ready), .h_write(hc_write),
      .h_addr(hc_addr), .h_wdata(hc_wdata), .h_rvalid(hc_rvalid), .h_rdata(hc_rdata),
      .e_valid(ec_valid), .e_ready(ec_ready), .e_write(ec_write),
      .e_addr(ec_addr), .e_wdata(ec_wdata), .e_rvalid(ec_rvalid), .e_rdata(ec_rdata),
      .c_valid(cc_valid), .c_ready(cc_ready), .c_write(cc_write),
      .c_addr(cc_addr), .c_wdata(cc_wdata), .c_rvalid(cc_rvalid), .c_rdata(cc_rdata),
      .idle(cfg_idle), .busy(cfg_busy)
   );

   fbh_port_route #(
      .AW(DAT_AW), .DW(DAT_DW), .MAX_OUT(MAX_OUT), .GATE_RDATA(GATE_RDATA)
   ) u_dat (
      .clk(clk), .rst_n(rst_n), .host_open(host_open), .eng_own(eng_own),
      .h_valid(hd_valid), .h_ready(hd_ready), .h_write(hd_write),
      .h_addr(hd_addr), .h_wdata(hd_wdata), .h_rvalid(hd_rvalid), .h_rdata(hd_rdata),
      .e_valid(ed_valid), .e_ready(ed_ready), .e_write(ed_write),
      .e_addr(ed_addr), .e_wdata(ed_wdata), .e_rvalid(ed_rvalid), .e_rdata(ed_rdata),
      .c_valid(cd_valid), .c_ready(cd_ready), .c_write(cd_write),
      .c_addr(cd_addr), .c_wdata(cd_wdata), .c_rvalid(cd_rvalid), .c_rdata(cd_rdata),
      .idle(dat_idle), .busy(dat_busy)
   );

endmodule

// File: rtl/fbh_checker.sv
module fbh_checker #(
   parameter  int MAX_OUT = 4,
   localparam int CW      = $clog2(MAX_OUT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eng_req,
   input logic          eng_grant,
   input logic          hc_ready,
   input logic          hd_ready,
   input logic          ec_ready,
   input logic          ed_ready,
   input logic          hc_rvalid,
   input logic          ec_rvalid,
   input logic          hd_rvalid,
   input logic          ed_rvalid,
   input logic          cc_valid,
   input logic          cd_valid,
   input logic          cfg_idle,
   input logic          dat_idle,
   input logic [CW-1:0] cfg_busy,
   input logic [CW-1:0] dat_busy
);

   p_grant_after_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_grant) |-> $past(cfg_idle && dat_idle && eng_req));

   p_host_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req || eng_grant) |-> (!hc_ready && !hd_ready));

   p_engine_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_grant |-> (!ec_ready && !ed_ready));

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_grant && !eng_req) |=> !eng_grant);

   p_cfg_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_busy == CW'(MAX_OUT)) |-> !cc_valid);

   p_dat_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_busy == CW'(MAX_OUT)) |-> !cd_valid);

   p_cfg_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hc_rvalid, ec_rvalid}));

   p_dat_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hd_rvalid, ed_rvalid}));

endmodule

bind flash_bus_handover fbh_checker #(.MAX_OUT(MAX_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_grant(eng_grant),
   .hc_ready(hc_ready), .hd_ready(hd_ready), .ec_ready(ec_ready), .ed_ready(ed_ready),
   .hc_rvalid(hc_rvalid), .ec_rvalid(ec_rvalid), .hd_rvalid(hd_rvalid), .ed_rvalid(ed_rvalid),
   .cc_valid(cc_valid), .cd_valid(cd_valid), .cfg_idle(cfg_idle), .dat_idle(dat_idle),
   .cfg_busy(cfg_busy), .dat_busy(dat_busy)
);

// File: tb/sim_flash_bus_handover.sv
module sim_flash_bus_handover;

   localparam int CLK_NS = 10;
   localparam int CAW    = 8;
   localparam int CDW    = 16;
   localparam int DAW    = 12;
   localparam int DDW    = 16;
   localparam int MAXO   = 3;
   localparam int LAST   = 3300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eng_req = 1'b0, eng_grant;
   logic hc_valid = 0, hc_ready, hc_write = 0, hc_rvalid;
   logic ec_valid = 0, ec_ready, ec_write = 0, ec_rvalid;
   logic cc_valid, cc_ready = 1, cc_write, cc_rvalid = 0;
   logic hd_valid = 0, hd_ready, hd_write = 0, hd_rvalid;
   logic ed_valid = 0, ed_ready, ed_write = 0, ed_rvalid;
   logic cd_valid, cd_ready = 1, cd_write, cd_rvalid = 0;
   logic [CAW-1:0] hc_addr = '0, ec_addr = '0, cc_addr;
   logic [CDW-1:0] hc_wdata = '0, ec_wdata = '0, cc_wdata, hc_rdata, ec_rdata, cc_rdata = '0;
   logic [DAW-1:0] hd_addr = '0, ed_addr = '0, cd_addr;
   logic [DDW-1:0] hd_wdata = '0, ed_wdata = '0, cd_wdata, hd_rdata, ed_rdata, cd_rdata = '0;

   flash_bus_handover #(
      .CFG_AW(CAW), .CFG_DW(CDW), .DAT_AW(DAW), .DAT_DW(DDW), .MAX_OUT(MAXO)
   ) u0 (.*);

   always #(CLK_NS / 2) clk = ~clk;

   int n_chk = 0, n_err = 0, cyc = 0;
   int mown = 0;                    // 0 host, 1 draining, 2 engine
   int tags [2][16];
   int head [2], cnt [2];
   int c_due [$], d_due [$];
   int n_grants = 0, n_abandon = 0;
   bit prev_grant = 0, done = 0;
   bit hc_fire = 0, ec_fire = 0, hd_fire = 0, ed_fire = 0;

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", rq, what, cyc, act, exp);
      end
   endtask

   // compare one path against the reference model
   task automatic check_path(input int k, input string nm,
      input logic c_rdy, h_v, e_v, h_rdy, e_rdy, c_v, h_rv, e_rv, c_rv,
      input logic [31:0] h_a, e_a, c_a, h_w, e_w, c_w,
      input logic h_wr, e_wr, c_wr,
      input logic [31:0] h_rd, e_rd, c_rd);
      bit open, room, ev;
      string rh, re;
      open = (mown == 0) && !eng_req;
      room = cnt[k] < MAXO;
      rh = !room ? "R9" : (open ? "R2" : "R3");
      re = !room ? "R9" : (mown == 2 ? "R5" : "R6");
      chk(rh, {nm, " host ready"},   32'(h_rdy), 32'(open && room && c_rdy));
      chk(re, {nm, " engine ready"}, 32'(e_rdy), 32'(mown == 2 && room && c_rdy));
      ev = room && ((mown == 2) ? e_v : (open && h_v));
      chk(mown == 2 ? re : rh, {nm, " ctrl valid"}, 32'(c_v), 32'(ev));
      if (ev) begin
         chk(mown == 2 ? "R5" : "R2", {nm, " ctrl addr"},  c_a, mown == 2 ? e_a : h_a);
         chk(mown == 2 ? "R5" : "R2", {nm, " ctrl wdata"}, c_w, mown == 2 ? e_w : h_w);
         chk(mown == 2 ? "R5" : "R2", {nm, " ctrl write"}, 32'(c_wr), 32'(mown == 2 ? e_wr : h_wr));
      end
      if (c_rv && cnt[k] > 0) begin
         chk("R8", {nm, " host rvalid"},   32'(h_rv), 32'(tags[k][head[k]] == 0));
         chk("R8", {nm, " engine rvalid"}, 32'(e_rv), 32'(tags[k][head[k]] == 1));
         if (tags[k][head[k]] == 0) chk("R8", {nm, " host rdata"}, h_rd, c_rd);
         else                        chk("R8", {nm, " engine rdata"}, e_rd, c_rd);
      end else begin
         chk("R8", {nm, " no response"}, 32'({h_rv, e_rv}), 32'(0));
      end
   endtask

   task automatic update_path(input int k, input logic c_rv, input logic c_fire);
      if (c_rv && cnt[k] > 0) begin
         head[k] = (head[k] + 1) % 16;
         cnt[k]--;
      end
      if (c_fire) begin
         tags[k][(head[k] + cnt[k]) % 16] = (mown == 2) ? 1 : 0;
         cnt[k]++;
      end
   endtask

   // monitor and reference model, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R1", "grant in reset", 32'(eng_grant), 0);
         chk("R1", "engine ready in reset", 32'({ec_ready, ed_ready}), 0);
         chk("R1", "ctrl valid in reset", 32'({cc_valid, cd_valid}), 0);
      end else if (!done) begin
         bit idle;
         chk(mown == 2 ? "R4" : "R7", "grant", 32'(eng_grant), 32'(mown == 2));
         if (eng_grant && !prev_grant) n_grants++;
         prev_grant = eng_grant;
         check_path(0, "cfg", cc_ready, hc_valid, ec_valid, hc_ready, ec_ready, cc_valid,
                    hc_rvalid, ec_rvalid, cc_rvalid, 32'(hc_addr), 32'(ec_addr), 32'(cc_addr),
                    32'(hc_wdata), 32'(ec_wdata), 32'(cc_wdata), hc_write, ec_write, cc_write,
                    32'(hc_rdata), 32'(ec_rdata), 32'(cc_rdata));
         check_path(1, "data", cd_ready, hd_valid, ed_valid, hd_ready, ed_ready, cd_valid,
                    hd_rvalid, ed_rvalid, cd_rvalid, 32'(hd_addr), 32'(ed_addr), 32'(cd_addr),
                    32'(hd_wdata), 32'(ed_wdata), 32'(cd_wdata), hd_write, ed_write, cd_write,
                    32'(hd_rdata), 32'(ed_rdata), 32'(cd_rdata));
         hc_fire = hc_valid && hc_ready;
         ec_fire = ec_valid && ec_ready;
         hd_fire = hd_valid && hd_ready;
         ed_fire = ed_valid && ed_ready;
         if (cc_valid && cc_ready) c_due.push_back(cyc + $urandom_range(1, 6));
         if (cd_valid && cd_ready) d_due.push_back(cyc + $urandom_range(1, 6));
         idle = (cnt[0] == 0) && (cnt[1] == 0);
         update_path(0, cc_rvalid, cc_valid && cc_ready);
         update_path(1, cd_rvalid, cd_valid && cd_ready);
         case (mown)
            0: if (eng_req) mown = 1;
            1: begin
               if (!eng_req) begin mown = 0; n_abandon++; end
               else if (idle) mown = 2;
            end
            default: if (!eng_req) mown = 0;
         endcase
      end
   end

   // stimulus: masters and controller, driven after the active edge
   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      forever begin
         bit phase_on;
         @(posedge clk);
         #1;
         cyc++;
         phase_on = (cyc < 3000) && ((cyc % 160) >= 100);
         if (!hc_valid || hc_fire) begin
            hc_valid = (cyc < LAST - 20) && ($urandom_range(0, 3) != 0);
            hc_addr  = CAW'($urandom);
            hc_wdata = CDW'($urandom);
            hc_write = 1'($urandom_range(0, 1));
         end
         if (!hd_valid || hd_fire) begin
            hd_valid = (cyc < LAST - 20) && ($urandom_range(0, 3) != 0);
            hd_addr  = DAW'($urandom);
            hd_wdata = DDW'($urandom);
            hd_write = 1'($urandom_range(0, 1));
         end
         if (!ec_valid || ec_fire) begin
            ec_valid = phase_on && ($urandom_range(0, 2) == 0);
            ec_addr  = CAW'($urandom);
            ec_wdata = CDW'($urandom);
            ec_write = 1'($urandom_range(0, 1));
         end
         if (!ed_valid || ed_fire) begin
            ed_valid = phase_on && ($urandom_range(0, 2) == 0);
            ed_addr  = DAW'($urandom);
            ed_wdata = DDW'($urandom);
            ed_write = 1'($urandom_range(0, 1));
         end
         hc_fire = 0; ec_fire = 0; hd_fire = 0; ed_fire = 0;
         // single-cycle pulse at 3100: a claim withdrawn mid-drain (R11)
         eng_req  = phase_on || ec_valid || ed_valid || (cyc == 3100);
         cc_ready = ($urandom_range(0, 3) != 0);
         cd_ready = ($urandom_range(0, 3) != 0);
         cc_rvalid = 1'b0;
         if (c_due.size() > 0 && c_due[0] <= cyc) begin
            void'(c_due.pop_front());
            cc_rvalid = 1'b1;
            cc_rdata  = CDW'($urandom);
         end
         cd_rvalid = 1'b0;
         if (d_due.size() > 0 && d_due[0] <= cyc) begin
            void'(d_due.pop_front());
            cd_rvalid = 1'b1;
            cd_rdata  = DDW'($urandom);
         end
      end
   end

   initial begin
      wait (cyc == LAST);
      @(negedge clk);
      done = 1;
      chk("R10", "repeated grants", 32'(n_grants >= 10), 1);
      chk("R11", "abandoned drain seen", 32'(n_abandon >= 1), 1);
      chk("R1", "all responses returned", 32'(cnt[0] + cnt[1]), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule